// File: doc/BRIEF.md
# JTAG Reconfiguration Trigger Controller

This block is an IEEE 1149.1 test access port with a 10-bit instruction register. Besides the usual bypass and identification data registers, it has one private instruction. While that instruction is current, the block pulls an external, active-low reconfiguration request line low. The line is meant to reach the configuration input of a downstream programmable device.

The line is open-drain. The block only enables or disables a pull-down. It never drives the line high: a pull-up on the board restores the level. The low pulse lasts exactly as long as the TAP controller dwells in Run-Test/Idle. The downstream device starts loading its configuration once the line is released, so no completion handshake comes back.

A sense input reads the level of the line back, and that level appears in the captured instruction pattern. Test software can therefore see whether some other agent is holding the line low.

Top module: `reconf_tap_ctrl`

## Requirements
- R1: During Capture-IR the 10-bit instruction shift register loads a fixed pattern. Bits 1:0 are 01, bit 2 is the level on cfg_line_sense, and bits 9:3 are zero. The pattern is shifted out on TDO least significant bit first.
- R2: The reconfiguration opcode is 10'b00_0110_0001. A newly shifted opcode becomes current only when the controller passes Update-IR. Shifting it in and then leaving through a reset produces no pulse.
- R3: cfg_pull_oe is 1 in exactly those TCK cycles in which the reconfiguration opcode is current and the controller is in Run-Test/Idle. Each dwell of N cycles in Run-Test/Idle gives a low pulse of N cycles. Re-entering Run-Test/Idle without loading a new instruction gives another pulse.
- R4: In the first cycle after the controller leaves Run-Test/Idle, cfg_pull_oe is 0. The line is then released to the pull-up and never driven high.
- R5: Under any current instruction other than the reconfiguration opcode, cfg_pull_oe stays 0 in every state, Run-Test/Idle included.
- R6: Test-Logic-Reset, and an asynchronous low on trst_n, make the identification instruction (10'b00_0000_0110) current. They also clear cfg_pull_oe at once. When HAS_IDCODE is 0, the bypass instruction becomes current instead.
- R7: Five consecutive TCK rising edges with TMS high bring the controller to Test-Logic-Reset from any state.
- R8: With the identification instruction current, Capture-DR loads the 32-bit IDCODE_VAL. Shift-DR then presents it on TDO least significant bit first.
- R9: The bypass instruction (all ones) selects a 1-bit register that captures 0. Bits shifted in on TDI appear on TDO one cycle later.
- R10: TDO and tdo_en change only on the falling edge of TCK. tdo_en is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: An opcode that is not recognised selects the 1-bit bypass register and never asserts cfg_pull_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge of TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge of TCK |
| tdo_en | output | 1 | Output enable for the TDO pad; 0 means high-impedance |
| cfg_pull_oe | output | 1 | Enable of the open-drain pull-down on the reconfiguration line; 1 pulls the line low |
| cfg_line_sense | input | 1 | Level read back from the reconfiguration line |

## Verification
The trigger is exercised with three kinds of instruction load: the reconfiguration opcode, the standard identification and bypass opcodes, and arbitrary unrecognised codes. Each load is followed by a TMS walk that enters, holds and leaves Run-Test/Idle. A pulse length that differs from the dwell shows an off-by-one in the output timing. A pulse under any other opcode shows a faulty decode. An opcode that is shifted in and then abandoned through Pause-IR and a reset shows whether the trigger takes effect before Update-IR. Holding the line low from outside during Capture-IR shows whether the sense path reaches the captured pattern.

// File: rtl/jtr_pkg.sv
package jtr_pkg;

    localparam int IR_W = 10;

    localparam logic [IR_W-1:0] OP_RECONF = 10'b00_0110_0001;
    localparam logic [IR_W-1:0] OP_IDCODE = 10'b00_0000_0110;
    localparam logic [IR_W-1:0] OP_BYPASS = {IR_W{1'b1}};

    typedef enum logic [3:0] {
        TS_TLR,
        TS_RTI,
        TS_SEL_DR,
        TS_CAP_DR,
        TS_SHIFT_DR,
        TS_EXIT1_DR,
        TS_PAUSE_DR,
        TS_EXIT2_DR,
        TS_UPD_DR,
        TS_SEL_IR,
        TS_CAP_IR,
        TS_SHIFT_IR,
        TS_EXIT1_IR,
        TS_PAUSE_IR,
        TS_EXIT2_IR,
        TS_UPD_IR
    } tap_state_e;

    // Standard TAP transition: returns the state reached after one TCK rise.
    function automatic tap_state_e tap_step(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            TS_TLR:      n = tms ? TS_TLR      : TS_RTI;
            TS_RTI:      n = tms ? TS_SEL_DR   : TS_RTI;
            TS_SEL_DR:   n = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: n = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: n = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: n = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   n = tms ? TS_SEL_DR   : TS_RTI;
            TS_SEL_IR:   n = tms ? TS_TLR      : TS_CAP_IR;
            TS_CAP_IR:   n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: n = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: n = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: n = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   n = tms ? TS_SEL_DR   : TS_RTI;
            default:     n = TS_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtr_tap_fsm.sv
module jtr_tap_fsm
    import jtr_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.st = tap_step(fsm_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            fsm_q.st <= TS_TLR;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_q = fsm_q.st;
    assign state_d = fsm_d.st;

endmodule

// File: rtl/jtr_ir_unit.sv
module jtr_ir_unit
    import jtr_pkg::*;
#(
    parameter logic [IR_W-1:0] DEF_OP = OP_IDCODE
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            line_sense,
    input  tap_state_e      state_q,
    output logic [IR_W-1:0] instr_q,
    output logic [IR_W-1:0] instr_d,
    output logic            ir_lsb
);

    localparam int PAD_W = IR_W - 3;

    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] cur;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state_q)
            TS_TLR:      ir_d.cur = DEF_OP;
            TS_CAP_IR:   ir_d.sr  = {{PAD_W{1'b0}}, line_sense, 2'b01};
            TS_SHIFT_IR: ir_d.sr  = {tdi, ir_q.sr[IR_W-1:1]};
            TS_UPD_IR:   ir_d.cur = ir_q.sr;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q.sr  <= '0;
            ir_q.cur <= DEF_OP;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign instr_q = ir_q.cur;
    assign instr_d = ir_d.cur;
    assign ir_lsb  = ir_q.sr[0];

endmodule

// File: rtl/jtr_dr_unit.sv
module jtr_dr_unit
    import jtr_pkg::*;
#(
    parameter bit              HAS_ID = 1'b1,
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h1A5C_E0DD
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_q,
    input  logic       sel_id,
    output logic       dr_lsb
);

    typedef struct packed {
        logic byp;
    } byp_t;

    byp_t byp_d, byp_q;

    always_comb begin
        byp_d = byp_q;
        case (state_q)
            TS_CAP_DR:   byp_d.byp = 1'b0;
            TS_SHIFT_DR: byp_d.byp = tdi;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q.byp <= 1'b0;
        end else begin
            byp_q <= byp_d;
        end
    end

    generate
        if (HAS_ID) begin : g_id
            typedef struct packed {
                logic [ID_W-1:0] sr;
            } id_t;

            id_t id_d, id_q;

            always_comb begin
                id_d = id_q;
                case (state_q)
                    TS_CAP_DR:   id_d.sr = ID_VAL;
                    TS_SHIFT_DR: id_d.sr = {tdi, id_q.sr[ID_W-1:1]};
                    default: ;
                endcase
            end

            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) begin
                    id_q.sr <= '0;
                end else begin
                    id_q <= id_d;
                end
            end

            assign dr_lsb = sel_id ? id_q.sr[0] : byp_q.byp;
        end else begin : g_no_id
            assign dr_lsb = byp_q.byp;
        end
    endgenerate

endmodule

// File: rtl/reconf_tap_ctrl.sv
module reconf_tap_ctrl
    import jtr_pkg::*;
#(
    parameter bit              HAS_IDCODE = 1'b1,
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h1A5C_E0DD
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic cfg_pull_oe,
    input  logic cfg_line_sense
);

    localparam logic [IR_W-1:0] DEF_OP = HAS_IDCODE ? OP_IDCODE : OP_BYPASS;

    tap_state_e      state_q;
    tap_state_e      state_d;
    logic [IR_W-1:0] instr_q;
    logic [IR_W-1:0] instr_d;
    logic            ir_lsb;
    logic            dr_lsb;
    logic            sel_id;

    jtr_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state_q),
        .state_d (state_d)
    );

    jtr_ir_unit #(
        .DEF_OP (DEF_OP)
    ) u_ir (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .line_sense (cfg_line_sense),
        .state_q    (state_q),
        .instr_q    (instr_q),
        .instr_d    (instr_d),
        .ir_lsb     (ir_lsb)
    );

    assign sel_id = HAS_IDCODE && (instr_q == OP_IDCODE);

    jtr_dr_unit #(
        .HAS_ID (HAS_IDCODE),
        .ID_W   (ID_W),
        .ID_VAL (IDCODE_VAL)
    ) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state_q (state_q),
        .sel_id  (sel_id),
        .dr_lsb  (dr_lsb)
    );

    // Pull-down enable: registered from next state and next instruction,
    // so it tracks the Run-Test/Idle dwell exactly and is glitch-free.
    typedef struct packed {
        logic oe;
    } pull_t;

    pull_t pull_d, pull_q;

    always_comb begin
        pull_d    = pull_q;
        pull_d.oe = (state_d == TS_RTI) && (instr_d == OP_RECONF);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            pull_q.oe <= 1'b0;
        end else begin
            pull_q <= pull_d;
        end
    end

    // Serial output stage, falling edge of TCK.
    typedef struct packed {
        logic tdo;
        logic en;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.en = (state_q == TS_SHIFT_IR) || (state_q == TS_SHIFT_DR);
        if (state_q == TS_SHIFT_IR) begin
            out_d.tdo = ir_lsb;
        end else if (state_q == TS_SHIFT_DR) begin
            out_d.tdo = dr_lsb;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            out_q.tdo <= 1'b1;
            out_q.en  <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cfg_pull_oe = pull_q.oe;
    assign tdo         = out_q.tdo;
    assign tdo_en      = out_q.en;

endmodule

// File: rtl/reconf_tap_ctrl_sva.sv
module reconf_tap_ctrl_sva
    import jtr_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            cfg_pull_oe,
    input logic            tdo_en,
    input tap_state_e      state_q,
    input logic [IR_W-1:0] instr_q
);

    logic [2:0] ones_cnt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ones_cnt <= 3'd0;
        end else if (tms) begin
            ones_cnt <= (ones_cnt == 3'd5) ? 3'd5 : ones_cnt + 3'd1;
        end else begin
            ones_cnt <= 3'd0;
        end
    end

    a_r3_low_while_idle: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == TS_RTI && instr_q == OP_RECONF) |-> cfg_pull_oe);

    a_r3_low_only_idle: assert property (@(posedge tck) disable iff (!trst_n)
        cfg_pull_oe |-> (state_q == TS_RTI));

    a_r4_release_on_exit: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state_q) == TS_RTI && state_q != TS_RTI) |-> !cfg_pull_oe);

    a_r5_other_instr_quiet: assert property (@(posedge tck) disable iff (!trst_n)
        (instr_q != OP_RECONF) |-> !cfg_pull_oe);

    a_r6_reset_state_released: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == TS_TLR) |-> !cfg_pull_oe);

    a_r2_instr_change_point: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(instr_q) |-> ($past(state_q) == TS_UPD_IR || $past(state_q) == TS_TLR));

    a_r7_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt == 3'd5) |-> (state_q == TS_TLR));

    a_r10_tdo_enable_window: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == TS_SHIFT_IR || state_q == TS_SHIFT_DR));

endmodule

bind reconf_tap_ctrl reconf_tap_ctrl_sva u_sva (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .cfg_pull_oe (cfg_pull_oe),
    .tdo_en      (tdo_en),
    .state_q     (state_q),
    .instr_q     (instr_q)
);

// File: tb/reconf_tap_ctrl_bench.sv
`timescale 1ns/100ps
module reconf_tap_ctrl_bench;
    import jtr_pkg::tap_state_e;
    import jtr_pkg::TS_TLR;
    import jtr_pkg::TS_RTI;
    import jtr_pkg::TS_SEL_DR;
    import jtr_pkg::TS_CAP_DR;
    import jtr_pkg::TS_SHIFT_DR;
    import jtr_pkg::TS_EXIT1_DR;
    import jtr_pkg::TS_PAUSE_DR;
    import jtr_pkg::TS_EXIT2_DR;
    import jtr_pkg::TS_UPD_DR;
    import jtr_pkg::TS_SEL_IR;
    import jtr_pkg::TS_CAP_IR;
    import jtr_pkg::TS_SHIFT_IR;
    import jtr_pkg::TS_EXIT1_IR;
    import jtr_pkg::TS_PAUSE_IR;
    import jtr_pkg::TS_EXIT2_IR;
    import jtr_pkg::TS_UPD_IR;

    localparam logic [31:0] ID_VALUE = 32'h1A5C_E0DD;
    localparam logic [9:0]  B_RECONF = 10'b00_0110_0001;
    localparam logic [9:0]  B_IDCODE = 10'b00_0000_0110;
    localparam logic [9:0]  B_BYPASS = 10'b11_1111_1111;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic ext_low = 1'b0;
    logic tdo, tdo_en, pull_oe;
    logic line;

    // Open-drain line with pull-up, plus an optional external holder.
    assign line = (pull_oe || ext_low) ? 1'b0 : 1'b1;

    reconf_tap_ctrl #(
        .HAS_IDCODE (1'b1),
        .ID_W       (32),
        .IDCODE_VAL (ID_VALUE)
    ) u_reconf_tap_ctrl (
        .tck            (tck),
        .trst_n         (trst_n),
        .tms            (tms),
        .tdi            (tdi),
        .tdo            (tdo),
        .tdo_en         (tdo_en),
        .cfg_pull_oe    (pull_oe),
        .cfg_line_sense (line)
    );

    always #2 tck = ~tck;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tap_state_e m_st = TS_TLR;
    logic [9:0] m_sr = '0;
    logic [9:0] m_cur = B_IDCODE;
    logic tdo_seen, tdo_post, line_post, line_pre;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic tap_state_e ref_next(tap_state_e s, logic t);
        case (s)
            TS_TLR:      return t ? TS_TLR : TS_RTI;
            TS_RTI:      return t ? TS_SEL_DR : TS_RTI;
            TS_SEL_DR:   return t ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR:   return t ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: return t ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: return t ? TS_UPD_DR : TS_PAUSE_DR;
            TS_PAUSE_DR: return t ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: return t ? TS_UPD_DR : TS_SHIFT_DR;
            TS_UPD_DR:   return t ? TS_SEL_DR : TS_RTI;
            TS_SEL_IR:   return t ? TS_TLR : TS_CAP_IR;
            TS_CAP_IR:   return t ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: return t ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: return t ? TS_UPD_IR : TS_PAUSE_IR;
            TS_PAUSE_IR: return t ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: return t ? TS_UPD_IR : TS_SHIFT_IR;
            default:     return t ? TS_SEL_DR : TS_RTI;
        endcase
    endfunction

    // One TCK cycle: drive after the falling edge, observe after the rising edge.
    task automatic clk(input logic t, input logic d);
        tap_state_e prev;
        logic in_shift;
        logic exp_low;
        string tag;
        @(negedge tck);
        #1;
        tms = t;
        tdi = d;
        tdo_seen = tdo;
        line_pre = line;
        in_shift = (m_st == TS_SHIFT_IR) || (m_st == TS_SHIFT_DR);
        check_eq("R10", "tdo_en", 32'(tdo_en), 32'(in_shift));
        @(posedge tck);
        prev = m_st;
        case (m_st)
            TS_TLR:      m_cur = B_IDCODE;
            TS_CAP_IR:   m_sr  = {7'b0, line_pre, 2'b01};
            TS_SHIFT_IR: m_sr  = {d, m_sr[9:1]};
            TS_UPD_IR:   m_cur = m_sr;
            default: ;
        endcase
        m_st = ref_next(m_st, t);
        #1;
        line_post = line;
        tdo_post  = tdo;
        if (in_shift) begin
            check_eq("R10", "tdo stable across rising edge", 32'(tdo_post), 32'(tdo_seen));
        end
        if (!ext_low) begin
            exp_low = (m_st == TS_RTI) && (m_cur == B_RECONF);
            if (prev == TS_RTI && m_st != TS_RTI) tag = "R4";
            else if (m_cur == B_RECONF) tag = "R3";
            else tag = "R5";
            check_eq(tag, "line level", 32'(line_post), 32'(!exp_low));
        end
    endtask

    task automatic do_trst();
        @(negedge tck);
        #1;
        trst_n = 1'b0;
        tms = 1'b1;
        #0.5;
        check_eq("R6", "pull released by trst", 32'(pull_oe), 32'd0);
        check_eq("R10", "tdo_en off in reset", 32'(tdo_en), 32'd0);
        m_st  = TS_TLR;
        m_cur = B_IDCODE;
        @(negedge tck);
        #1;
        trst_n = 1'b1;
    endtask

    task automatic go_idle();
        for (int i = 0; i < 5; i++) clk(1'b1, 1'b0);
        clk(1'b0, 1'b0);
    endtask

    // From Run-Test/Idle; ends in Update-IR.
    task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
        clk(1'b1, 1'b0);
        clk(1'b1, 1'b0);
        clk(1'b0, 1'b0);
        clk(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) begin
            clk(i == 9, op[i]);
            cap[i] = tdo_seen;
        end
        clk(1'b1, 1'b0);
    endtask

    // From Run-Test/Idle; ends back in Run-Test/Idle.
    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        clk(1'b1, 1'b0);
        clk(1'b0, 1'b0);
        clk(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            clk(i == n - 1, din[i]);
            dout[i] = tdo_seen;
        end
        clk(1'b1, 1'b0);
        clk(1'b0, 1'b0);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [9:0]  cap;
        logic [31:0] dout;
        int low;
        void'($urandom(32'h5EED_1234));

        // Reset state (R6, R10)
        do_trst();
        go_idle();
        check_eq("R6", "line after reset", 32'(line), 32'd1);

        // Default instruction is IDCODE (R6, R8)
        scan_dr(32, 32'h0, dout);
        check_eq("R8", "idcode after reset", dout, ID_VALUE);

        // Load reconfiguration opcode, captured pattern (R1, R2)
        load_ir(B_RECONF, cap);
        check_eq("R1", "capture pattern line high", 32'(cap), 32'h005);
        check_eq("R2", "no pulse in Update-IR", 32'(line_post), 32'd1);

        // Pulse of 7 cycles (R3)
        low = 0;
        for (int i = 0; i < 7; i++) begin
            clk(1'b0, 1'b0);
            if (!line_post) low++;
        end
        check_eq("R3", "pulse length 7", 32'(low), 32'd7);
        clk(1'b1, 1'b0);
        check_eq("R4", "released after leaving idle", 32'(line_post), 32'd1);
        clk(1'b0, 1'b0);
        clk(1'b1, 1'b0);
        clk(1'b1, 1'b0);
        low = 0;
        for (int i = 0; i < 3; i++) begin
            clk(1'b0, 1'b0);
            if (!line_post) low++;
        end
        check_eq("R3", "second dwell pulse length 3", 32'(low), 32'd3);

        // Five TMS-high cycles from RTI under reconf (R7, R6)
        for (int i = 0; i < 5; i++) clk(1'b1, 1'b0);
        clk(1'b0, 1'b0);
        check_eq("R6", "no pulse after TLR", 32'(line_post), 32'd1);
        scan_dr(32, 32'h0, dout);
        check_eq("R6", "idcode selected by TLR", dout, ID_VALUE);

        // Sense readback with line held low externally (R1)
        ext_low = 1'b1;
        load_ir(B_BYPASS, cap);
        ext_low = 1'b0;
        check_eq("R1", "capture pattern line low", 32'(cap), 32'h001);
        clk(1'b0, 1'b0);

        // Bypass register (R9)
        scan_dr(8, 32'hB2, dout);
        check_eq("R9", "bypass delay", dout & 32'hFF, (32'hB2 << 1) & 32'hFF);

        // R7: reach TLR from Shift-DR under bypass
        clk(1'b1, 1'b0);
        clk(1'b0, 1'b0);
        clk(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) clk(1'b1, 1'b0);
        check_eq("R7", "tdo_en off after five ones", 32'(tdo_en), 32'd0);
        clk(1'b0, 1'b0);
        scan_dr(32, 32'h0, dout);
        check_eq("R7", "idcode restored via TLR", dout, ID_VALUE);

        // Unrecognised opcode (R11, R5)
        load_ir(10'h2AA, cap);
        for (int i = 0; i < 3; i++) clk(1'b0, 1'b0);
        check_eq("R11", "no pulse unknown op", 32'(line_post), 32'd1);
        scan_dr(8, 32'h5C, dout);
        check_eq("R11", "unknown op acts as bypass", dout & 32'hFF, (32'h5C << 1) & 32'hFF);

        // IDCODE current, dwell in idle (R5)
        load_ir(B_IDCODE, cap);
        for (int i = 0; i < 4; i++) clk(1'b0, 1'b0);
        check_eq("R5", "no pulse under idcode", 32'(line_post), 32'd1);

        // Shift reconf opcode without update, abandon via trst (R2)
        clk(1'b1, 1'b0);
        clk(1'b1, 1'b0);
        clk(1'b0, 1'b0);
        clk(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) clk(i == 9, B_RECONF[i]);
        clk(1'b0, 1'b0);
        clk(1'b0, 1'b0);
        check_eq("R2", "no pulse before update", 32'(line_post), 32'd1);
        do_trst();
        low = 0;
        clk(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            clk(1'b0, 1'b0);
            if (!line_post) low++;
        end
        check_eq("R2", "abandoned opcode inactive", 32'(low), 32'd0);

        // Constrained random: opcode choice plus random TMS walks (R3, R4, R5)
        for (int it = 0; it < 60; it++) begin
            logic [9:0] op;
            int sel;
            int len;
            sel = $urandom % 4;
            case (sel)
                0, 1:    op = B_RECONF;
                2:       op = (($urandom % 2) == 0) ? B_IDCODE : B_BYPASS;
                default: op = 10'($urandom);
            endcase
            load_ir(op, cap);
            len = 1 + ($urandom % 15);
            for (int k = 0; k < len; k++) begin
                clk(($urandom % 3) == 0, 1'($urandom));
            end
            go_idle();
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule